// File: doc/BRIEF.md
# Iterative Sine/Cosine Rotator

This block works out the sine and cosine of a signed angle in radians. It uses one shift-and-add rotation stage again and again, once per clock, and feeds the results back through three registers: two hold the vector components and one holds the angle that is still left to rotate. At the start the vector is set to (1/K, 0), where 1/K is the inverse of the rotation gain. Because of that preload, once all micro-rotations are done the vector components are the cosine and the sine directly, with no scaling step after them.

A requester drives the angle and raises `load`. While `load` stays high, the input multiplexers keep copying the external values into the registers. When `load` drops, the controller switches the registers to feedback and runs a fixed count of micro-rotations. It then stops the register enable, so the result is frozen and `done_o` is raised. The result stays until the next `load`. A `load` that arrives while the rotations are running is ignored.

Data words are 16-bit two's complement with 14 fractional bits (Q2.14, 1.0 = 16384). The angle range is -pi/2 to +pi/2, which is -25736 to +25736 in this format.

Top module: `sincos_serial_core`

## Requirements
- R1: After a synchronous reset, `done_o` is 0 and both `cos_o` and `sin_o` are 0.
- R2: While `load` is high, the block keeps taking the external operands. During this time `cos_o` shows the gain-compensated start value 9949 (0.607253 in Q2.14), `sin_o` shows 0, and `done_o` is 0.
- R3: `done_o` goes high exactly 17 rising edges after the first rising edge at which `load` is sampled low following a load. That is one edge to capture the operands plus sixteen micro-rotations, one per clock. It is low on every edge before that.
- R4: For a positive angle in range, `cos_o` and `sin_o` are each within 6 LSB of round(cos(a)·16384) and round(sin(a)·16384), where a = angle_i/16384.
- R5: For a negative angle, the rotation direction follows the sign of the remaining angle, so `sin_o` comes out negative and is within 6 LSB of the real value. This includes the end point -pi/2 (angle_i = -25736).
- R6: For an angle of 0 the outputs are within 6 LSB of cos = 16384 and sin = 0. At +pi/2 (angle_i = 25736) they are within 6 LSB of cos = 0 and sin = 16384.
- R7: Once `done_o` is high and `load` stays low, `done_o`, `cos_o` and `sin_o` hold their values for any number of cycles, even if `angle_i` changes.
- R8: A `load` pulse during the micro-rotations, including one sampled on the final rotation edge, is ignored. The completion time and the result are the same as if the pulse had not occurred.
- R9: When `load` is sampled high while `done_o` is high, `done_o` falls after that edge and a new computation begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Operand capture request; rotation starts when it is released |
| angle_i | input | 16 | Angle in radians, Q2.14, limited to ±pi/2 |
| cos_o | output | 16 | Cosine result, Q2.14 |
| sin_o | output | 16 | Sine result, Q2.14 |
| done_o | output | 1 | High while the frozen result is valid |

## Verification
The final micro-rotation and an incoming load request can land on the same clock edge. That edge is where the controller must finish the rotation and also ignore the request. The bench raises `load` in the half-cycle just before the sixteenth rotation edge and drops it one cycle later. It then checks that `done_o` rises on schedule, that the result still matches the real-valued sine and cosine, and that the result does not move afterwards. A second case sends a `load` that is sampled in the frozen state, and checks that `done_o` drops right after that edge.

// File: rtl/sc_pkg.sv
package sc_pkg;

    parameter int W      = 16;
    parameter int FRAC   = 14;
    parameter int ITERS  = 16;
    localparam int IW    = $clog2(ITERS);

    typedef logic signed [W-1:0] word_t;
    typedef logic [IW-1:0]       idx_t;

    typedef struct packed {
        word_t x;
        word_t y;
        word_t z;
    } vec_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SELECT = 2'd1,
        ST_ITER   = 2'd2,
        ST_HOLD   = 2'd3
    } state_t;

    // 1/K for sixteen micro-rotations, Q2.14
    localparam word_t INV_GAIN = word_t'(9949);

    localparam idx_t LAST_IDX = idx_t'(ITERS - 1);

    // arctan(2^-i) scaled by 2^14, rounded
    function automatic word_t atan_lut(input idx_t i);
        word_t r;
        case (i)
            idx_t'(0):  r = word_t'(12868);
            idx_t'(1):  r = word_t'(7596);
            idx_t'(2):  r = word_t'(4014);
            idx_t'(3):  r = word_t'(2037);
            idx_t'(4):  r = word_t'(1023);
            idx_t'(5):  r = word_t'(512);
            idx_t'(6):  r = word_t'(256);
            idx_t'(7):  r = word_t'(128);
            idx_t'(8):  r = word_t'(64);
            idx_t'(9):  r = word_t'(32);
            idx_t'(10): r = word_t'(16);
            idx_t'(11): r = word_t'(8);
            idx_t'(12): r = word_t'(4);
            idx_t'(13): r = word_t'(2);
            idx_t'(14): r = word_t'(1);
            default:    r = word_t'(0);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
    import sc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic sel,
    output logic ena,
    output idx_t idx,
    output logic done
);

    state_t st_q, st_d;
    idx_t   idx_q, idx_d;

    always_comb begin
        st_d  = st_q;
        idx_d = idx_q;
        case (st_q)
            ST_IDLE: begin
                if (load) st_d = ST_SELECT;
            end
            ST_SELECT: begin
                idx_d = '0;
                if (!load) st_d = ST_ITER;
            end
            ST_ITER: begin
                idx_d = idx_q + idx_t'(1);
                if (idx_q == LAST_IDX) st_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (load) st_d = ST_SELECT;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            idx_q <= '0;
        end else begin
            st_q  <= st_d;
            idx_q <= idx_d;
        end
    end

    assign sel  = (st_q == ST_SELECT);
    assign ena  = (st_q == ST_ITER);
    assign idx  = idx_q;
    assign done = (st_q == ST_HOLD);

endmodule

// File: rtl/sc_stage.sv
module sc_stage
    import sc_pkg::*;
(
    input  vec_t cur,
    input  idx_t idx,
    output vec_t nxt
);

    word_t xs, ys, ang;
    logic  pos;

    always_comb begin
        xs  = cur.x >>> idx;
        ys  = cur.y >>> idx;
        ang = atan_lut(idx);
        pos = ~cur.z[W-1];
        if (pos) begin
            nxt.x = cur.x - ys;
            nxt.y = cur.y + xs;
            nxt.z = cur.z - ang;
        end else begin
            nxt.x = cur.x + ys;
            nxt.y = cur.y - xs;
            nxt.z = cur.z + ang;
        end
    end

endmodule

// File: rtl/sc_regs.sv
module sc_regs
    import sc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sel,
    input  logic  ena,
    input  word_t angle,
    input  vec_t  fb,
    output vec_t  q
);

    vec_t ext;

    always_comb begin
        ext.x = INV_GAIN;
        ext.y = '0;
        ext.z = angle;
    end

    always_ff @(posedge clk) begin
        if (rst)      q <= '0;
        else if (sel) q <= ext;
        else if (ena) q <= fb;
    end

endmodule

// File: rtl/sincos_serial_core.sv
module sincos_serial_core
    import sc_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] angle_i,
    output logic [W-1:0] cos_o,
    output logic [W-1:0] sin_o,
    output logic         done_o
);

    logic sel_w, ena_w, done_w;
    idx_t idx_w;
    vec_t cur_w, nxt_w;

    sc_ctrl u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .sel  (sel_w),
        .ena  (ena_w),
        .idx  (idx_w),
        .done (done_w)
    );

    sc_stage u_stage (
        .cur (cur_w),
        .idx (idx_w),
        .nxt (nxt_w)
    );

    sc_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .sel   (sel_w),
        .ena   (ena_w),
        .angle (word_t'(angle_i)),
        .fb    (nxt_w),
        .q     (cur_w)
    );

    assign cos_o  = cur_w.x;
    assign sin_o  = cur_w.y;
    assign done_o = done_w;

endmodule

// File: rtl/sc_chk.sv
module sc_chk
    import sc_pkg::*;
(
    input logic         clk,
    input logic         rst,
    input logic         load,
    input logic [W-1:0] cos_o,
    input logic [W-1:0] sin_o,
    input logic         done_o,
    input logic         ena_w,
    input logic         sel_w,
    input idx_t         idx_w,
    input vec_t         cur_w
);

    // R1
    reset_clears_done_chk: assert property (@(posedge clk)
        rst |=> !done_o);

    // R2
    select_loads_start_chk: assert property (@(posedge clk) disable iff (rst)
        sel_w |=> (cos_o == W'(INV_GAIN)) && (sin_o == '0));

    // R3
    iter_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ena_w && $past(ena_w)) |-> (idx_w == $past(idx_w) + idx_t'(1)));

    // R3
    done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> ($past(ena_w) && $past(idx_w) == LAST_IDX));

    // R4
    angle_converged_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ((cur_w.z < word_t'(8)) && (cur_w.z > -word_t'(8))));

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && !load) |=> (done_o && $stable(cos_o) && $stable(sin_o)));

    // R8
    done_only_by_load_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(done_o) |-> $past(load));

    // R9
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && load) |=> (!done_o && sel_w));

endmodule

bind sincos_serial_core sc_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .cos_o  (cos_o),
    .sin_o  (sin_o),
    .done_o (done_o),
    .ena_w  (ena_w),
    .sel_w  (sel_w),
    .idx_w  (idx_w),
    .cur_w  (cur_w)
);

// File: tb/sincos_serial_core_tb.sv
module sincos_serial_core_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load = 1'b0;
    logic [15:0] angle_i = '0;
    logic [15:0] cos_o, sin_o;
    logic        done_o;

    int nvec = 0;
    int nbad = 0;

    always #4 clk = ~clk;

    sincos_serial_core dut_i (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .angle_i (angle_i),
        .cos_o   (cos_o),
        .sin_o   (sin_o),
        .done_o  (done_o)
    );

    task automatic check_near(input string req, input int act, input int exp, input int tol);
        nvec++;
        if ((act - exp > tol) || (exp - act > tol)) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d (tol %0d)", req, act, exp, tol);
        end
    endtask

    function automatic int ref_cos(input int a);
        real r = real'(a) / 16384.0;
        return int'($floor($cos(r) * 16384.0 + 0.5));
    endfunction

    function automatic int ref_sin(input int a);
        real r = real'(a) / 16384.0;
        return int'($floor($sin(r) * 16384.0 + 0.5));
    endfunction

    // load for 'hold' cycles, release, wait to completion edge (17 posedges)
    task automatic run_op(input int a, input int hold);
        @(negedge clk);
        angle_i = 16'(a);
        load    = 1'b1;
        repeat (hold) @(negedge clk);
        load = 1'b0;
        repeat (17) @(negedge clk);
    endtask

    task automatic check_result(input string req, input int a);
        check_near({req, " done"}, int'(done_o), 1, 0);
        check_near({req, " cos"}, int'($signed(cos_o)), ref_cos(a), 6);
        check_near({req, " sin"}, int'($signed(sin_o)), ref_sin(a), 6);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1
        check_near("R1 done", int'(done_o), 0, 0);
        check_near("R1 cos", int'(cos_o), 0, 0);
        check_near("R1 sin", int'(sin_o), 0, 0);
        rst = 1'b0;
    endtask

    task automatic t_handshake();
        @(negedge clk);
        angle_i = 16'(8000);
        load    = 1'b1;
        repeat (4) @(negedge clk);
        // R2: operands captured while load held
        check_near("R2 cos preload", int'($signed(cos_o)), 9949, 0);
        check_near("R2 sin preload", int'($signed(sin_o)), 0, 0);
        check_near("R2 done", int'(done_o), 0, 0);
        load = 1'b0;
        repeat (16) @(negedge clk);
        // R3: not yet done after 16 edges
        check_near("R3 done early", int'(done_o), 0, 0);
        @(negedge clk);
        check_near("R3 done on time", int'(done_o), 1, 0);
        check_result("R4", 8000);
    endtask

    task automatic t_positive();
        int angs[4] = '{3000, 12868, 17157, 22000};
        foreach (angs[k]) begin
            run_op(angs[k], 1);
            check_result("R4", angs[k]);
        end
    endtask

    task automatic t_negative();
        int angs[3] = '{-5000, -17157, -25736};
        foreach (angs[k]) begin
            run_op(angs[k], 2);
            check_result("R5", angs[k]);
            nvec++;
            if (!sin_o[15]) begin
                nbad++;
                $display("FAIL R5 sin sign actual=%0d expected=negative", $signed(sin_o));
            end
        end
    endtask

    task automatic t_bounds();
        run_op(0, 1);
        check_result("R6 zero", 0);
        run_op(25736, 1);
        check_result("R6 half-pi", 25736);
    endtask

    task automatic t_hold();
        int c0, s0;
        run_op(6000, 1);
        c0 = int'(cos_o);
        s0 = int'(sin_o);
        for (int k = 0; k < 10; k++) begin
            angle_i = 16'(k * 1111 - 3000);
            @(negedge clk);
        end
        // R7
        check_near("R7 done held", int'(done_o), 1, 0);
        check_near("R7 cos held", int'(cos_o), c0, 0);
        check_near("R7 sin held", int'(sin_o), s0, 0);
    endtask

    task automatic t_load_busy();
        // pulse mid-run
        @(negedge clk);
        angle_i = 16'(-9000);
        load    = 1'b1;
        @(negedge clk);
        load = 1'b0;
        repeat (5) @(negedge clk);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        repeat (10) @(negedge clk);
        // R8
        check_near("R8 mid pulse not done", int'(done_o), 0, 0);
        @(negedge clk);
        check_result("R8 mid pulse", -9000);
        // pulse sampled on the final rotation edge
        @(negedge clk);
        angle_i = 16'(14000);
        load    = 1'b1;
        @(negedge clk);
        load = 1'b0;
        repeat (16) @(negedge clk);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        check_result("R8 final edge", 14000);
        repeat (3) @(negedge clk);
        check_result("R8 final edge held", 14000);
    endtask

    task automatic t_restart();
        run_op(4000, 1);
        check_near("R9 done before", int'(done_o), 1, 0);
        @(negedge clk);
        angle_i = 16'(-4000);
        load    = 1'b1;
        @(negedge clk);
        // R9
        check_near("R9 done cleared", int'(done_o), 0, 0);
        load = 1'b0;
        repeat (17) @(negedge clk);
        check_result("R9 restart", -4000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        t_reset();
        t_handshake();
        t_positive();
        t_negative();
        t_bounds();
        t_hold();
        t_load_busy();
        t_restart();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule